// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block runs one external memory access at a time on behalf of a processor core that masters the external bus. A single-cycle request pulse from the core starts the access, but only while the bus is granted to this master and the chip is not in a low-power state. An access strobe is then held for a programmed minimum number of wait states. An active-low transfer-acknowledge pin can extend the access for as long as the pin stays deasserted. When the access ends, a one-cycle done pulse goes back to the core.

An access lasts as long as the longer of two limits: the programmed minimum and the point at which the acknowledge pin is seen asserted. Acknowledge extension is only possible when the programmed minimum is one wait state or more. A zero-wait access always ends after one strobe cycle. A control input can route the acknowledge pin through a two-stage synchronizer first, which adds two clocks to its sampling. A registered bus-request output asks for the bus. In a low-power state this output either drops or holds its last value, depending on a hold control.

Top module: `ext_bus_wait_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the cycle after a clocked reset, `acc_stb_o`, `done_o` and `bus_req_o` are all 0.
- R2: A request pulse on `req_i` starts an access only if it is sampled while the controller is idle, `grant_i` is 1 and `lowpwr_i` is 0. `acc_stb_o` rises in the cycle after that clock edge. A request under any other condition produces no strobe.
- R3: If `ack_n_i` is held at 0 and `wait_cnt_i` = W with W >= 1, `acc_stb_o` stays high for exactly W+1 cycles. `done_o` is 1 in the first cycle that `acc_stb_o` is 0 again.
- R4: If W >= 1 and `ack_n_i` is 1 (deasserted), the access is extended with no upper limit. With the synchronizer off, driving `ack_n_i` to 0 during strobe cycle K (K >= W+1) ends the access after exactly K strobe cycles.
- R5: With W = 0 the strobe lasts exactly one cycle, whatever the level of `ack_n_i`.
- R6: With `sync_en_i` = 1, the acknowledge path has two extra clocks of latency. Asserting `ack_n_i` during strobe cycle K gives max(W+1, K+2) strobe cycles.
- R7: `ack_n_i` has no effect while no access is in progress: toggling it while idle leaves `acc_stb_o` and `done_o` at 0.
- R8: A request that arrives while an access is in progress is dropped. Exactly one access and one done pulse occur.
- R9: `done_o` is a single-cycle pulse and is never high together with `acc_stb_o`.
- R10: `bus_req_o` is registered. Outside low power it is 1 in the cycle after an edge at which `req_i` was 1 or an access was in progress, and 0 otherwise. With `lowpwr_i` = 1 and `hold_i` = 0, it is 0 after the next edge.
- R11: With `lowpwr_i` = 1 and `hold_i` = 1, `bus_req_o` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Access request pulse from the core |
| wait_cnt_i | input | 5 | Programmed minimum wait states (0 to 31) |
| sync_en_i | input | 1 | 1 = acknowledge passes through the two-stage synchronizer |
| ack_n_i | input | 1 | Transfer acknowledge pin, active low |
| grant_i | input | 1 | 1 = this master owns the bus |
| lowpwr_i | input | 1 | 1 = stop or wait low-power state |
| hold_i | input | 1 | 1 = bus request keeps its value in low power |
| acc_stb_o | output | 1 | Access strobe, high for the whole access |
| done_o | output | 1 | One-cycle completion pulse to the core |
| bus_req_o | output | 1 | Bus request output |

## Verification
The programmed count can expire in the same cycle that the acknowledge pin is first sampled asserted. In that case the two completion conditions meet at one clock edge. The bench provokes this by asserting the acknowledge exactly in strobe cycle W+1. It then checks that the strobe lasts W+1 cycles, not W+2, and that one done pulse follows. A second collision, a fresh request landing inside an access, is judged by counting strobe cycles and done pulses across the whole window.

// File: rtl/ewc_pkg.sv
// Shared types for the external bus wait-state controller.
package ewc_pkg;
    // Access sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACT  = 2'd1,
        ST_DONE = 2'd2
    } ewc_state_t;
endpackage

// File: rtl/ewc_ack_sync.sv
// Acknowledge conditioning. Passes the active-low acknowledge pin through a
// chain of STAGES flops, or bypasses the chain, depending on sync_en.
// Assumes the pin idles high (deasserted); the chain resets to that level.
module ewc_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_en,
    input  logic ack_n_raw,
    output logic ack_n_eff
);
    logic [STAGES-1:0] chain;

    // Shift the pin level through the synchronizer stages
    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain[i] <= 1'b1;
                else if (i == 0)
                    chain[i] <= ack_n_raw;
                else
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    // Pick the synchronized or the direct level
    always_comb ack_n_eff = sync_en ? chain[STAGES-1] : ack_n_raw;
endmodule

// File: rtl/ewc_wait_timer.sv
// Down-counter for the programmed minimum wait states. Loads the count at
// the start of an access and steps toward zero while enabled. Assumes the
// load and the decrement are never requested together.
module ewc_wait_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic             expired
);
    logic [CNT_W-1:0] remain;

    // Load on access start, count down while the access runs
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (step && remain != '0)
            remain <= remain - 1'b1;
    end

    // Flag that the minimum has been served
    always_comb expired = (remain == '0);
endmodule

// File: rtl/ewc_busreq.sv
// Registered bus-request output. Requests the bus while the core asks or an
// access runs. In low power it drops, or holds its value if hold is set.
module ewc_busreq (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic lowpwr,
    input  logic hold,
    output logic bus_req
);
    // Next request level, with the low-power policy applied
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_req <= 1'b0;
        else if (lowpwr)
            bus_req <= hold ? bus_req : 1'b0;
        else
            bus_req <= want;
    end
endmodule

// File: rtl/ext_bus_wait_ctrl.sv
// External bus wait-state controller, top level. Runs one access at a time:
// strobe for at least the programmed wait states, then until the (optionally
// synchronized) acknowledge is seen low, then a one-cycle done pulse.
// Assumes req_i is a pulse and that grant_i reflects bus ownership.
module ext_bus_wait_ctrl
    import ewc_pkg::*;
#(
    parameter int CNT_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [CNT_W-1:0] wait_cnt_i,
    input  logic             sync_en_i,
    input  logic             ack_n_i,
    input  logic             grant_i,
    input  logic             lowpwr_i,
    input  logic             hold_i,
    output logic             acc_stb_o,
    output logic             done_o,
    output logic             bus_req_o
);
    ewc_state_t state;
    logic       accept;
    logic       min_zero_q;
    logic       tmr_expired;
    logic       ack_n_eff;
    logic       ack_ok;
    logic       active;

    // Start condition for a new access
    always_comb accept = (state == ST_IDLE) && req_i && grant_i && !lowpwr_i;
    always_comb active = (state == ST_ACT);
    // Acknowledge counts only for the master during a running access
    always_comb ack_ok = active && grant_i && !ack_n_eff;

    ewc_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_en   (sync_en_i),
        .ack_n_raw (ack_n_i),
        .ack_n_eff (ack_n_eff)
    );

    ewc_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (wait_cnt_i),
        .step     (active),
        .expired  (tmr_expired)
    );

    ewc_busreq u_breq (
        .clk     (clk),
        .rst_n   (rst_n),
        .want    (req_i || active),
        .lowpwr  (lowpwr_i),
        .hold    (hold_i),
        .bus_req (bus_req_o)
    );

    // Remember whether this access was programmed with zero wait states
    always_ff @(posedge clk) begin
        if (!rst_n)
            min_zero_q <= 1'b0;
        else if (accept)
            min_zero_q <= (wait_cnt_i == '0);
    end

    // Access sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (accept) state <= ST_ACT;
                ST_ACT:  if (tmr_expired && (min_zero_q || ack_ok)) state <= ST_DONE;
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from the sequencer state
    always_comb acc_stb_o = (state == ST_ACT);
    always_comb done_o    = (state == ST_DONE);
endmodule

// File: rtl/ext_bus_wait_ctrl_chk.sv
// Property checker for ext_bus_wait_ctrl, bound to every instance.
module ext_bus_wait_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic req_i,
    input logic grant_i,
    input logic lowpwr_i,
    input logic hold_i,
    input logic acc_stb_o,
    input logic done_o,
    input logic bus_req_o
);
    // After a clocked reset, all outputs are quiet
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!acc_stb_o && !done_o && !bus_req_o));

    // A strobe only rises after a legal request
    assert_start_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_stb_o) |-> $past(req_i && grant_i && !lowpwr_i));

    // Strobe end is marked by done in the same cycle
    assert_done_on_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(acc_stb_o) |-> done_o);

    // Done is one cycle wide and exclusive with the strobe
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !acc_stb_o);

    // Low power without hold drops the bus request
    assert_lp_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lowpwr_i && !hold_i) |=> !bus_req_o);

    // Low power with hold freezes the bus request
    assert_lp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lowpwr_i && hold_i) |=> $stable(bus_req_o));
endmodule

bind ext_bus_wait_ctrl ext_bus_wait_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .grant_i   (grant_i),
    .lowpwr_i  (lowpwr_i),
    .hold_i    (hold_i),
    .acc_stb_o (acc_stb_o),
    .done_o    (done_o),
    .bus_req_o (bus_req_o)
);

// File: tb/ext_bus_wait_ctrl_test.sv
// Directed bench for ext_bus_wait_ctrl. Drives and samples on the falling edge.
module ext_bus_wait_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_i = 1'b0;
    logic [4:0] wait_cnt_i = '0;
    logic       sync_en_i = 1'b0;
    logic       ack_n_i = 1'b1;
    logic       grant_i = 1'b1;
    logic       lowpwr_i = 1'b0;
    logic       hold_i = 1'b0;
    logic       acc_stb_o, done_o, bus_req_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ext_bus_wait_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .wait_cnt_i(wait_cnt_i),
        .sync_en_i(sync_en_i), .ack_n_i(ack_n_i), .grant_i(grant_i),
        .lowpwr_i(lowpwr_i), .hold_i(hold_i), .acc_stb_o(acc_stb_o),
        .done_o(done_o), .bus_req_o(bus_req_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        ack_n_i = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // One access; kdrv = strobe cycle in which ack is driven low (0 = from start)
    task automatic run_access(input string req, input int w, input bit sy, input int kdrv);
        int len = 0;
        int exp;
        wait_cnt_i = w[4:0];
        sync_en_i  = sy;
        ack_n_i    = (kdrv == 0) ? 1'b0 : 1'b1;
        req_i      = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        while (acc_stb_o && len < 500) begin
            len++;
            if (done_o) check({req, " done during strobe"}, 1, 0);
            if (kdrv != 0 && len == kdrv) ack_n_i = 1'b0;
            @(negedge clk);
        end
        if (w == 0) exp = 1;
        else if (kdrv == 0) exp = w + 1;
        else exp = (w + 1 > kdrv + (sy ? 2 : 0)) ? w + 1 : kdrv + (sy ? 2 : 0);
        check({req, " strobe length"}, len, exp);
        check({req, " done after strobe"}, done_o, 1);
        @(negedge clk);
        check({req, " done single cycle R9"}, done_o, 0);
        settle();
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 stb", acc_stb_o, 0);
        check("R1 done", done_o, 0);
        check("R1 breq", bus_req_o, 0);
    endtask

    task automatic t_no_start();
        int seen = 0;
        grant_i = 1'b0; req_i = 1'b1; @(negedge clk); req_i = 1'b0;
        repeat (3) begin seen += acc_stb_o; @(negedge clk); end
        grant_i = 1'b1;
        lowpwr_i = 1'b1; req_i = 1'b1; @(negedge clk); req_i = 1'b0; lowpwr_i = 1'b0;
        repeat (3) begin seen += acc_stb_o; @(negedge clk); end
        check("R2 no strobe without grant or in low power", seen, 0);
        settle();
    endtask

    task automatic t_ack_idle();
        int seen = 0;
        for (int i = 0; i < 8; i++) begin
            ack_n_i = i[0];
            @(negedge clk);
            seen += acc_stb_o + done_o;
        end
        check("R7 ack ignored while idle", seen, 0);
        settle();
    endtask

    task automatic t_req_overlap();
        int stb = 0;
        int dn = 0;
        wait_cnt_i = 5'd4; sync_en_i = 1'b0; ack_n_i = 1'b0;
        req_i = 1'b1; @(negedge clk); req_i = 1'b0;
        for (int i = 0; i < 14; i++) begin
            req_i = (i == 2);
            stb += acc_stb_o; dn += done_o;
            @(negedge clk);
        end
        req_i = 1'b0;
        check("R8 strobe cycles with overlapping request", stb, 5);
        check("R8 done pulses", dn, 1);
        settle();
    endtask

    task automatic t_busreq();
        grant_i = 1'b0; req_i = 1'b1;
        @(negedge clk);
        check("R10 request raises bus_req", bus_req_o, 1);
        lowpwr_i = 1'b1; hold_i = 1'b0;
        @(negedge clk);
        check("R10 low power drops bus_req", bus_req_o, 0);
        lowpwr_i = 1'b0;
        @(negedge clk);
        check("R10 bus_req back after low power", bus_req_o, 1);
        lowpwr_i = 1'b1; hold_i = 1'b1; req_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 hold keeps bus_req high", bus_req_o, 1);
        lowpwr_i = 1'b0; hold_i = 1'b0;
        @(negedge clk);
        check("R10 bus_req falls with no request", bus_req_o, 0);
        lowpwr_i = 1'b1; hold_i = 1'b1;
        repeat (2) @(negedge clk);
        check("R11 hold keeps bus_req low", bus_req_o, 0);
        lowpwr_i = 1'b0; hold_i = 1'b0; grant_i = 1'b1;
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_no_start();
        run_access("R3 w=1",                  1, 1'b0, 0);
        run_access("R3 w=6",                  6, 1'b0, 0);
        run_access("R3 w=31",                31, 1'b0, 0);
        run_access("R4 late ack",             2, 1'b0, 7);
        run_access("R4 long stretch",         2, 1'b0, 40);
        run_access("R4 ack at count expiry",  3, 1'b0, 4);
        run_access("R4 early ack",            5, 1'b0, 2);
        run_access("R5 zero wait ack high",   0, 1'b0, 30);
        run_access("R5 zero wait ack low",    0, 1'b0, 0);
        run_access("R6 sync late ack",        2, 1'b1, 6);
        run_access("R6 sync early ack",       6, 1'b1, 2);
        run_access("R6 sync held ack",        3, 1'b1, 0);
        t_ack_idle();
        t_req_overlap();
        t_busreq();
        rst_n = 1'b0;
        @(negedge clk);
        t_reset();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule